// File: doc/BRIEF.md
# Last-Value Load Predictor Table

This block guesses the result of a load before memory returns it, using the last value that the same load instruction produced. The table is direct-mapped and indexed by the load's program counter. Each entry keeps a valid bit, an address tag, the last loaded word and a 2-bit saturating confidence counter. A front-end stage presents a load PC on the lookup port. In the same cycle it gets back a flag that says whether a guess is offered, and the guessed word.

When the load resolves, the pipeline presents the load PC and the real data on the update port. On a tag hit, the block raises confidence if the stored word was right. If the stored word was wrong, it lowers confidence and keeps the new word. On a miss, it claims the entry for the new load with zero confidence. The block does not handle squash or recovery. It only reports the guess and keeps its own table consistent.

Top module: `load_value_predictor`

## Requirements
- R1: After reset every entry is invalid and no lookup yields a prediction until the entry has been trained by updates.
- R2: The entry index is PC bits [IDX_W+1:2] and the tag is PC bits [PC_W-1:IDX_W+2]. PC bits [1:0] take no part in either.
- R3: `predValid` is 1 only when `lookupEn` is 1, the indexed entry is valid, its tag equals the lookup tag and its confidence is at least THRESH (default 2). `predValue` is then the stored word, and 0 otherwise.
- R4: An update that hits an entry with an equal stored word increments the confidence by one, holding at 3.
- R5: An update that hits an entry with a different stored word decrements the confidence by one, holding at 0, and replaces the stored word with the update word.
- R6: An update that finds the entry invalid or its tag different writes the new tag and word, marks the entry valid and sets its confidence to 0.
- R7: When a lookup and an update address the same entry in the same cycle, the lookup answers from the state the entry had before that update.
- R8: With `updValid` at 0 no entry changes, and an update alters only the entry it indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupEn | input | 1 | A lookup is requested this cycle |
| lookupPc | input | PC_W | PC of the load being looked up |
| predValid | output | 1 | A prediction is offered |
| predValue | output | DATA_W | Predicted load word (0 when no prediction) |
| updValid | input | 1 | A resolved load is reported this cycle |
| updPc | input | PC_W | PC of the resolved load |
| updValue | input | DATA_W | Word the resolved load actually returned |

## Verification
The hardest behaviour to reach from the ports is the saturation of the confidence counter at both ends. Neither the counter nor its limits is visible. Each limit shows up only as a difference in when predictions appear or stop after further updates. The stimulus drives one entry past 3 with repeated matching updates and then gives one mismatch, which must still leave a prediction. It also drives the entry below 0 with repeated mismatches, after which exactly two matches must be needed before a guess returns. A randomized phase over a small pool of aliasing PCs and two data words then mixes hits, evictions and same-cycle lookup and update traffic.

// File: rtl/lvp_pkg.sv
`timescale 1ns/1ps
package lvp_pkg;
  localparam int CONF_W = 2;

  // Per-update commands issued by the control to the datapath
  typedef struct packed {
    logic allocate;      // claim entry for a new load
    logic confUp;        // raise confidence by one
    logic confDown;      // lower confidence by one
    logic replaceValue;  // keep the newly observed word
  } lvpStrobes_t;
endpackage

// File: rtl/lvp_ctrl.sv
`timescale 1ns/1ps
module lvp_ctrl
  import lvp_pkg::*;
(
  input  logic              updValid,
  input  logic              updHit,
  input  logic              updValMatch,
  input  logic [CONF_W-1:0] updConf,
  output lvpStrobes_t       strobes
);
  localparam logic [CONF_W-1:0] CONF_TOP = '1;

  always_comb begin
    strobes              = '0;
    strobes.allocate     = updValid && !updHit;
    strobes.confUp       = updValid && updHit && updValMatch && (updConf != CONF_TOP);
    strobes.confDown     = updValid && updHit && !updValMatch && (updConf != '0);
    strobes.replaceValue = updValid && updHit && !updValMatch;
  end
endmodule

// File: rtl/lvp_datapath.sv
`timescale 1ns/1ps
module lvp_datapath
  import lvp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupEn,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              predValid,
  output logic [DATA_W-1:0] predValue,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DATA_W-1:0] updValue,
  input  lvpStrobes_t       strobes,
  output logic              updHit,
  output logic              updValMatch,
  output logic [CONF_W-1:0] updConf
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;
  localparam logic [CONF_W-1:0] CONF_TOP = '1;
  localparam logic [CONF_W-1:0] CONF_THR = CONF_W'(THRESH);

  logic [ENTRIES-1:0]             validArr;
  logic [ENTRIES-1:0][TAG_W-1:0]  tagArr;
  logic [ENTRIES-1:0][DATA_W-1:0] valArr;
  logic [ENTRIES-1:0][CONF_W-1:0] confArr;

  logic [IDX_W-1:0] lkIdx, updIdx;
  logic [TAG_W-1:0] lkTag, updTag;
  logic             lkHit;
  logic             unusedOffset;

  assign lkIdx  = lookupPc[IDX_W+1:2];
  assign lkTag  = lookupPc[PC_W-1:IDX_W+2];
  assign updIdx = updPc[IDX_W+1:2];
  assign updTag = updPc[PC_W-1:IDX_W+2];
  assign unusedOffset = ^{lookupPc[1:0], updPc[1:0]};

  // Lookup side: reads the registered state, so a same-cycle update is not seen
  assign lkHit     = validArr[lkIdx] && (tagArr[lkIdx] == lkTag);
  assign predValid = lookupEn && lkHit && (confArr[lkIdx] >= CONF_THR);
  assign predValue = predValid ? valArr[lkIdx] : '0;

  // Update side: status of the addressed entry for the control
  assign updHit      = validArr[updIdx] && (tagArr[updIdx] == updTag);
  assign updValMatch = (valArr[updIdx] == updValue);
  assign updConf     = confArr[updIdx];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic sel;
    assign sel = updValid && (updIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validArr[e] <= 1'b0;
        tagArr[e]   <= '0;
        valArr[e]   <= '0;
        confArr[e]  <= '0;
      end else if (sel) begin
        if (strobes.allocate) begin
          validArr[e] <= 1'b1;
          tagArr[e]   <= updTag;
          valArr[e]   <= updValue;
          confArr[e]  <= '0;
        end else begin
          if (strobes.confUp)       confArr[e] <= confArr[e] + 1'b1;
          if (strobes.confDown)     confArr[e] <= confArr[e] - 1'b1;
          if (strobes.replaceValue) valArr[e]  <= updValue;
        end
      end
    end
  end

  // R4
  conf_inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updHit && updValMatch) |=>
      confArr[$past(updIdx)] == (($past(updConf) == CONF_TOP) ? CONF_TOP
                                                              : CONF_W'($past(updConf) + 1'b1)));

  // R5
  conf_dec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updHit && !updValMatch) |=>
      (confArr[$past(updIdx)] == (($past(updConf) == '0) ? '0
                                                         : CONF_W'($past(updConf) - 1'b1)))
      && (valArr[$past(updIdx)] == $past(updValue)));

  // R6
  alloc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && !updHit) |=>
      validArr[$past(updIdx)] && (confArr[$past(updIdx)] == '0)
      && (tagArr[$past(updIdx)] == $past(updTag))
      && (valArr[$past(updIdx)] == $past(updValue)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |=> $stable(confArr) && $stable(validArr) && $stable(valArr) && $stable(tagArr));
endmodule

// File: rtl/load_value_predictor.sv
`timescale 1ns/1ps
module load_value_predictor
  import lvp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupEn,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              predValid,
  output logic [DATA_W-1:0] predValue,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DATA_W-1:0] updValue
);
  lvpStrobes_t       strobes;
  logic              updHit, updValMatch;
  logic [CONF_W-1:0] updConf;

  lvp_ctrl u_ctrl (
    .updValid    (updValid),
    .updHit      (updHit),
    .updValMatch (updValMatch),
    .updConf     (updConf),
    .strobes     (strobes)
  );

  lvp_datapath #(
    .PC_W(PC_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .THRESH(THRESH)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookupEn    (lookupEn),
    .lookupPc    (lookupPc),
    .predValid   (predValid),
    .predValue   (predValue),
    .updValid    (updValid),
    .updPc       (updPc),
    .updValue    (updValue),
    .strobes     (strobes),
    .updHit      (updHit),
    .updValMatch (updValMatch),
    .updConf     (updConf)
  );
endmodule

// File: tb/load_value_predictor_test.sv
`timescale 1ns/1ps
module load_value_predictor_test;
  localparam int PC_W = 32, DATA_W = 32, IDX_W = 4, THRESH = 2;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookupEn = 1'b0, updValid = 1'b0;
  logic [PC_W-1:0] lookupPc = '0, updPc = '0;
  logic [DATA_W-1:0] updValue = '0;
  logic predValid;
  logic [DATA_W-1:0] predValue;

  always #2.5 clk = ~clk;

  load_value_predictor #(.PC_W(PC_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .THRESH(THRESH)) uut (
    .clk(clk), .rst_n(rst_n), .lookupEn(lookupEn), .lookupPc(lookupPc),
    .predValid(predValid), .predValue(predValue),
    .updValid(updValid), .updPc(updPc), .updValue(updValue));

  // Reference model built from the requirements
  bit              mValid [ENTRIES];
  logic [TAG_W-1:0] mTag  [ENTRIES];
  logic [DATA_W-1:0] mVal [ENTRIES];
  int              mConf  [ENTRIES];

  typedef struct { logic v; logic [DATA_W-1:0] d; string req; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic drive(input logic le, input logic [PC_W-1:0] lp, input logic uv,
                       input logic [PC_W-1:0] up, input logic [DATA_W-1:0] ud, input string req);
    exp_t e;
    int li, ui;
    bit hit;
    @(negedge clk);
    lookupEn = le; lookupPc = lp; updValid = uv; updPc = up; updValue = ud;
    li = int'(lp[IDX_W+1:2]);
    hit = mValid[li] && (mTag[li] == lp[PC_W-1:IDX_W+2]);
    e.v = le && hit && (mConf[li] >= THRESH);
    e.d = e.v ? mVal[li] : '0;
    e.req = req;
    q.push_back(e);
    if (uv && rst_n) begin
      ui = int'(up[IDX_W+1:2]);
      if (mValid[ui] && mTag[ui] == up[PC_W-1:IDX_W+2]) begin
        if (mVal[ui] == ud) begin
          if (mConf[ui] < 3) mConf[ui]++;
        end else begin
          if (mConf[ui] > 0) mConf[ui]--;
          mVal[ui] = ud;
        end
      end else begin
        mValid[ui] = 1; mTag[ui] = up[PC_W-1:IDX_W+2]; mVal[ui] = ud; mConf[ui] = 0;
      end
    end
  endtask

  task automatic upd(input logic [PC_W-1:0] up, input logic [DATA_W-1:0] ud, input string req);
    drive(1'b0, up, 1'b1, up, ud, req);
  endtask

  task automatic look(input logic [PC_W-1:0] lp, input string req);
    drive(1'b1, lp, 1'b0, lp, '0, req);
  endtask

  // Monitor: compare outputs against queued expectations, away from the edge
  initial begin
    forever begin : mon
      exp_t e;
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (predValid !== e.v || predValue !== e.d) begin
          fails++;
          $display("FAIL %s: got valid=%0b value=%h, expected valid=%0b value=%h",
                   e.req, predValid, predValue, e.v, e.d);
        end
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finishRun();
    end
  end

  localparam logic [PC_W-1:0] PC_A = 32'h0000_1044; // index 1
  localparam logic [PC_W-1:0] PC_B = 32'h0000_2044; // index 1, other tag
  localparam logic [PC_W-1:0] PC_C = 32'h0000_1048; // index 2
  localparam logic [PC_W-1:0] PC_D = 32'h0000_104C; // index 3

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 0; mTag[i] = '0; mVal[i] = '0; mConf[i] = 0;
    end
    // R1: reset state, updates during reset are ignored
    drive(1'b1, PC_A, 1'b1, PC_A, 32'h5, "R1");
    drive(1'b1, PC_A, 1'b1, PC_A, 32'h5, "R1");
    look(PC_A, "R1");
    rst_n = 1'b1;
    look(PC_A, "R1");
    look(PC_C, "R1");
    // R6: allocation with zero confidence
    upd(PC_A, 32'h11, "R6");
    look(PC_A, "R6");
    // R4 / R3: confidence climbs to threshold
    upd(PC_A, 32'h11, "R4");
    look(PC_A, "R3");
    upd(PC_A, 32'h11, "R4");
    look(PC_A, "R3");
    // R2: byte offset ignored, tag compared
    look(PC_A + 1, "R2");
    look(PC_A + 3, "R2");
    look(PC_B, "R2");
    // R4: saturation at 3, then one mismatch still predicts
    upd(PC_A, 32'h11, "R4");
    upd(PC_A, 32'h11, "R4");
    upd(PC_A, 32'h11, "R4");
    upd(PC_A, 32'h22, "R5");
    look(PC_A, "R4");
    // R5: decrement to and hold at 0, value replaced
    upd(PC_A, 32'h33, "R5");
    look(PC_A, "R5");
    upd(PC_A, 32'h44, "R5");
    upd(PC_A, 32'h55, "R5");
    upd(PC_A, 32'h55, "R5");
    look(PC_A, "R5");
    upd(PC_A, 32'h55, "R5");
    look(PC_A, "R5");
    // R7: same-cycle lookup sees the old confidence
    upd(PC_C, 32'h77, "R7");
    upd(PC_C, 32'h77, "R7");
    drive(1'b1, PC_C, 1'b1, PC_C, 32'h77, "R7");
    look(PC_C, "R7");
    // R3: lookup disabled gives nothing
    drive(1'b0, PC_C, 1'b0, PC_C, '0, "R3");
    // R8: idle and neighbouring updates leave entry C alone
    drive(1'b0, PC_C, 1'b0, PC_C, 32'hdead, "R8");
    upd(PC_D, 32'h99, "R8");
    look(PC_C, "R8");
    // R6: alias eviction
    upd(PC_B, 32'h99, "R6");
    look(PC_A, "R6");
    look(PC_B, "R6");
    // Mixed traffic over aliasing PCs
    for (int n = 0; n < 400; n++) begin
      logic [PC_W-1:0] pool [5];
      pool[0] = PC_A; pool[1] = PC_B; pool[2] = PC_C; pool[3] = 32'h0000_3048; pool[4] = PC_D;
      drive(1'b1, pool[$urandom % 5], 1'($urandom % 4 != 0), pool[$urandom % 5],
            ($urandom % 3 == 0) ? 32'hB : 32'hA, "R3");
    end
    drive(1'b0, PC_A, 1'b0, PC_A, '0, "R8");
    @(negedge clk); #3;
    done = 1;
    finishRun();
  end
endmodule